// File: doc/BRIEF.md
# Switch-Stepped Shift Register with Fixed Preset

This block is a small shift register that advances by one bit only when a qualified strobe arrives, not on every system clock. The strobe comes from the rising edge of a conditioned switch line. A second conditioned switch gives the bit that enters the register on each step. A push button, once pressed and then let go, overwrites the whole register with the fixed pattern 0xA5. The register contents go to eight LED outputs, and the outgoing bit is also available as a serial output.

All inputs must already be debounced and synchronous to the system clock. Each control input passes through a one-flop edge detector inside the block, and every register update happens on the rising system clock edge. The register width and the preset word are parameters.

Top module: `strobe_shreg_top`

## Requirements
- R1: While rst_ni is low, led_o is all zeros and ser_o is 0. The edge history of both control inputs is cleared.
- R2: On the first clock edge at which step_sw_i is sampled high after being sampled low, the register moves each bit one place toward the most significant bit and puts ser_sw_i into bit 0. The new value shows on led_o after that edge.
- R3: If step_sw_i stays high, stays low, or falls, the register does not shift. With no load pending, led_o keeps its value.
- R4: ser_o always equals the most significant bit of the register, which is led_o[WIDTH-1].
- R5: Pressing preset_btn_i (a low-to-high change) has no effect on the register. On the first clock edge at which the button is sampled low after being sampled high, the register takes the PRESET value (0xA5 by default).
- R6: If a button release and a step rising edge are seen at the same clock edge, the preset load wins and the register becomes PRESET.
- R7: WIDTH rising edges with ser_sw_i at 1 fill the register with ones. Further edges with ser_sw_i at 0 push zeros in at bit 0.
- R8: A change on ser_sw_i with no step rising edge does not change led_o.
- R9: A step switch that is already high when reset is released counts as a rising edge at the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all updates happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_sw_i | input | 1 | Conditioned switch that gives the bit shifted in |
| step_sw_i | input | 1 | Conditioned switch; each rising edge advances the register once |
| preset_btn_i | input | 1 | Conditioned button; release loads PRESET |
| led_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Register MSB (outgoing bit) |

## Verification
The hardest case to reach is a button release and a step rising edge landing on the same clock edge. Only one input pattern produces it: the button must be high in the previous cycle and the step switch low, and in the next cycle the two must flip together. The bench sets this up on purpose. It then runs a sweep over every ordered pair of input triples, so each history state meets each next input. The case of a step switch held high through reset is set up by asserting the switch before reset is released.

// File: rtl/strobe_shreg_pkg.sv
package strobe_shreg_pkg;
  localparam int unsigned WIDTH_DEF = 8;
  localparam logic [7:0] PRESET_DEF = 8'hA5;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/strobe_edge_det.sv
module strobe_edge_det #(
  parameter strobe_shreg_pkg::edge_kind_e KIND = strobe_shreg_pkg::EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic prev_o,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  generate
    if (KIND == strobe_shreg_pkg::EDGE_RISE) begin : g_rise
      assign pulse_o = lvl_i & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~lvl_i & prev_q;
    end
  endgenerate

  assign prev_o = prev_q;
endmodule

// File: rtl/strobe_shreg_core.sv
module strobe_shreg_core #(
  parameter int unsigned WIDTH = strobe_shreg_pkg::WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             step_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] shifted;

  // bit 0 takes the serial input, every other bit takes its lower neighbour
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      if (b == 0) begin : g_lsb
        assign shifted[b] = ser_i;
      end else begin : g_up
        assign shifted[b] = q[b-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= par_i;    // load has priority over step
    else if (step_i) q <= shifted;
  end

  assign par_o = q;
  assign ser_o = q[MSB];
endmodule

// File: rtl/strobe_shreg_top.sv
module strobe_shreg_top #(
  parameter int unsigned      WIDTH  = strobe_shreg_pkg::WIDTH_DEF,
  parameter logic [WIDTH-1:0] PRESET = WIDTH'(strobe_shreg_pkg::PRESET_DEF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_sw_i,
  input  logic             step_sw_i,
  input  logic             preset_btn_i,
  output logic [WIDTH-1:0] led_o,
  output logic             ser_o
);
  logic step_prev, step_pulse;
  logic btn_prev, btn_release;

  strobe_edge_det #(.KIND(strobe_shreg_pkg::EDGE_RISE)) u_step_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (step_sw_i),
    .prev_o (step_prev),
    .pulse_o(step_pulse)
  );

  strobe_edge_det #(.KIND(strobe_shreg_pkg::EDGE_FALL)) u_btn_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (preset_btn_i),
    .prev_o (btn_prev),
    .pulse_o(btn_release)
  );

  strobe_shreg_core #(.WIDTH(WIDTH)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(btn_release),
    .par_i (PRESET),
    .step_i(step_pulse),
    .ser_i (ser_sw_i),
    .par_o (led_o),
    .ser_o (ser_o)
  );
endmodule

// File: rtl/strobe_shreg_chk.sv
module strobe_shreg_chk #(
  parameter int unsigned      WIDTH  = 8,
  parameter logic [WIDTH-1:0] PRESET = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_sw_i,
  input logic             step_sw_i,
  input logic             preset_btn_i,
  input logic             step_prev,
  input logic             btn_prev,
  input logic [WIDTH-1:0] led_o,
  input logic             ser_o
);
  logic rise_seen, rel_seen;
  assign rise_seen = step_sw_i & ~step_prev;
  assign rel_seen  = btn_prev & ~preset_btn_i;

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_seen && !rel_seen) |=> led_o == {$past(led_o[WIDTH-2:0]), $past(ser_sw_i)});

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_seen && !rel_seen) |=> $stable(led_o));

  p_msb_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_o == led_o[WIDTH-1]);

  p_preset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_seen |=> led_o == PRESET);

  p_load_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_seen && rise_seen) |=> led_o == PRESET);
endmodule

bind strobe_shreg_top strobe_shreg_chk #(.WIDTH(WIDTH), .PRESET(PRESET)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_sw_i    (ser_sw_i),
  .step_sw_i   (step_sw_i),
  .preset_btn_i(preset_btn_i),
  .step_prev   (step_prev),
  .btn_prev    (btn_prev),
  .led_o       (led_o),
  .ser_o       (ser_o)
);

// File: tb/strobe_shreg_top_tb_top.sv
module strobe_shreg_top_tb_top;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] PRE = 8'hA5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_sw_i = 1'b0;
  logic step_sw_i = 1'b0;
  logic preset_btn_i = 1'b0;
  logic [W-1:0] led_o;
  logic ser_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_q = '0;
  logic m_step = 1'b0;
  logic m_btn = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  strobe_shreg_top #(.WIDTH(W), .PRESET(PRE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_sw_i(ser_sw_i), .step_sw_i(step_sw_i),
    .preset_btn_i(preset_btn_i), .led_o(led_o), .ser_o(ser_o)
  );

  task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // apply one input triple for one clock, update model, compare
  task automatic tick(input logic s, input logic st, input logic b);
    logic rise, rel;
    string tag;
    ser_sw_i = s; step_sw_i = st; preset_btn_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    rise = st & ~m_step;
    rel  = m_btn & ~b;
    if (rel && rise) tag = "R6";
    else if (rel)    tag = "R5";
    else if (rise)   tag = "R2";
    else             tag = "R3/R8";
    if (rel)       exp_q = PRE;
    else if (rise) exp_q = {exp_q[W-2:0], s};
    m_step = st; m_btn = b;
    cmp(tag, led_o, exp_q);
    cmp("R4", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, exp_q[W-1]});
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with step high held across reset for R9
    step_sw_i = 1'b1; ser_sw_i = 1'b1;
    repeat (3) @(negedge clk_i);
    cmp("R1", led_o, '0);
    cmp("R1", {{(W-1){1'b0}}, ser_o}, '0);
    rst_ni = 1'b1;
    // R9 first edge after reset counts as a rise
    tick(1, 1, 0);
    cmp("R9", led_o, 8'h01);

    // R8 serial bit wiggles, step held high: no change
    tick(0, 1, 0); tick(1, 1, 0); tick(0, 1, 0);
    cmp("R8", led_o, 8'h01);
    // R3 falling edge and low hold: no shift
    tick(1, 0, 0); tick(1, 0, 0);
    cmp("R3", led_o, 8'h01);

    // R7 fill with ones then push zeros
    for (int i = 0; i < W; i++) begin
      tick(1, 1, 0); tick(1, 0, 0);
    end
    cmp("R7", led_o, 8'hFF);
    for (int i = 0; i < 3; i++) begin
      tick(0, 1, 0); tick(0, 0, 0);
    end
    cmp("R7", led_o, 8'hF8);

    // R5 press holds, release loads preset
    tick(0, 0, 1); tick(0, 0, 1);
    cmp("R5", led_o, 8'hF8);
    tick(0, 0, 0);
    cmp("R5", led_o, PRE);

    // R4 shift the preset out and watch the MSB
    for (int i = 0; i < W; i++) begin
      cmp("R4", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, exp_q[W-1]});
      tick(0, 1, 0); tick(0, 0, 0);
    end
    cmp("R4", led_o, 8'h00);

    // R6 release and rise on the same edge
    tick(1, 0, 1);
    tick(1, 1, 0);
    cmp("R6", led_o, PRE);

    // sweep all ordered pairs of input triples
    for (int a = 0; a < 8; a++) begin
      for (int c = 0; c < 8; c++) begin
        tick(a[0], a[1], a[2]);
        tick(c[0], c[1], c[2]);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule